// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a video raster, one pixel per clock. Software describes each line as an active width followed by a total blanking width. Within that blanking, the sync pulse is placed by a delay, counted from the end of active video, and by a width. The vertical direction works the same way in lines. Each of the three strobes has its own polarity select. The current pixel and line positions are also output, so that a pixel source can follow the raster.

For interlaced video the vertical fields are programmed per field, at half the frame values. When the frame's total vertical blanking is odd, a half-line flag is set. In that case every second field (field ID 1) carries one extra blanking line, and its vertical sync is moved by half a line period. The field ID flips at the start of each vertical blanking interval. The configuration is copied into shadow registers only while the generator is stopped or at the last pixel of a field. A write made in the middle of a field therefore takes effect from the next field onwards.

Top module: `rtg_top`

## Requirements
- R1: `hcount` steps by one each clock from 0 to hact+hblank-1 and then returns to 0. `vcount` increments when `hcount` wraps. It returns to 0 after the last line of the field, which is line vact+vblank-1, or line vact+vblank when R7 adds a line.
- R2: The raw data-enable is true exactly when `hcount` < hact and `vcount` < vact.
- R3: The raw horizontal sync is true exactly when hact+hdly <= `hcount` < hact+hdly+hwid.
- R4: Outside the R7 case, the raw vertical sync is true for whole lines with vact+vdly <= `vcount` < vact+vdly+vwid.
- R5: Each output equals its raw signal when its polarity bit is 1 (active high) and the inverse when the bit is 0. While the generator is stopped, every raw signal is false.
- R6: With interlace set, `field_id` inverts on the clock at which `vcount` moves from vact-1 to vact. With interlace clear, `field_id` reads 0.
- R7: With interlace and half-line both set, a field whose `field_id` is 1 during its blanking has one extra blanking line. Its vertical sync rises at `hcount` = floor((hact+hblank)/2) on line vact+vdly and falls at that same pixel on line vact+vdly+vwid.
- R8: Configuration is captured while stopped and on the clock that ends a field. A change made inside a field has no effect until the next field.
- R9: Dropping `en` returns both counters and `field_id` to 0 and the strobes to their inactive level at the next clock. After `en` rises, the first clock shows pixel 0 of line 0 and counting continues from there.
- R10: A low `rst_n` at a clock edge (synchronous) clears both counters, `field_id` and the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable |
| cfg_hact | input | 13 | Active pixels per line |
| cfg_hblank | input | 13 | Blanking pixels per line |
| cfg_hdly | input | 13 | Pixels from end of active to hsync start |
| cfg_hwid | input | 10 | Hsync width in pixels |
| cfg_vact | input | 13 | Active lines per field |
| cfg_vblank | input | 8 | Blanking lines per field |
| cfg_vdly | input | 8 | Lines from end of active to vsync start |
| cfg_vwid | input | 6 | Vsync width in lines |
| cfg_hs_pol | input | 1 | Hsync polarity, 1 = active high |
| cfg_vs_pol | input | 1 | Vsync polarity, 1 = active high |
| cfg_de_pol | input | 1 | Data-enable polarity, 1 = active high |
| cfg_ilace | input | 1 | Interlaced field timing |
| cfg_halfline | input | 1 | Odd frame blanking: extra line and half-line vsync in field 1 |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field_id | output | 1 | Current field |
| hcount | output | 14 | Current pixel position |
| vcount | output | 14 | Current line position |

## Verification
The hardest behaviour to reach is the half-line field. It needs interlace, the half-line flag and field 1 all at once. It then shows itself only on two lines, at one pixel each, and in a blanking interval that is one line longer than usual. The stimulus runs interlaced configurations for four fields, so that both field parities go through their blanking. A cycle-accurate model in the bench predicts every pixel, including the half-way vsync edges. A mid-field change of the active width shows the field-boundary capture rule. A disable at the start of field 1 shows that the field ID returns to 0.

// File: rtl/rtg_pkg.sv
// Shared defaults and helpers for the raster timing generator.
package rtg_pkg;
    localparam int unsigned H_W_DEF   = 13; // hactive, hblank, hsync delay
    localparam int unsigned HSW_W_DEF = 10; // hsync width
    localparam int unsigned VA_W_DEF  = 13; // vactive
    localparam int unsigned VB_W_DEF  = 8;  // vblank, vsync delay
    localparam int unsigned VSW_W_DEF = 6;  // vsync width

    // Convert a true-high strobe to the selected output level.
    function automatic logic apply_pol(input logic raw, input logic active_high);
        return active_high ? raw : ~raw;
    endfunction
endpackage

// File: rtl/rtg_shadow.sv
// Shadow copy of the timing configuration.
// Assumes: load is asserted while stopped and on the clock that ends a field.
module rtg_shadow #(
    parameter int unsigned H_W   = 13,
    parameter int unsigned HSW_W = 10,
    parameter int unsigned VA_W  = 13,
    parameter int unsigned VB_W  = 8,
    parameter int unsigned VSW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [H_W-1:0]   in_hact,
    input  logic [H_W-1:0]   in_hblank,
    input  logic [H_W-1:0]   in_hdly,
    input  logic [HSW_W-1:0] in_hwid,
    input  logic [VA_W-1:0]  in_vact,
    input  logic [VB_W-1:0]  in_vblank,
    input  logic [VB_W-1:0]  in_vdly,
    input  logic [VSW_W-1:0] in_vwid,
    input  logic [4:0]       in_flags,
    output logic [H_W-1:0]   sh_hact,
    output logic [H_W-1:0]   sh_hblank,
    output logic [H_W-1:0]   sh_hdly,
    output logic [HSW_W-1:0] sh_hwid,
    output logic [VA_W-1:0]  sh_vact,
    output logic [VB_W-1:0]  sh_vblank,
    output logic [VB_W-1:0]  sh_vdly,
    output logic [VSW_W-1:0] sh_vwid,
    output logic [4:0]       sh_flags
);
    // Capture the live configuration when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hact   <= '0;
            sh_hblank <= '0;
            sh_hdly   <= '0;
            sh_hwid   <= '0;
            sh_vact   <= '0;
            sh_vblank <= '0;
            sh_vdly   <= '0;
            sh_vwid   <= '0;
            sh_flags  <= '0;
        end else if (load) begin
            sh_hact   <= in_hact;
            sh_hblank <= in_hblank;
            sh_hdly   <= in_hdly;
            sh_hwid   <= in_hwid;
            sh_vact   <= in_vact;
            sh_vblank <= in_vblank;
            sh_vdly   <= in_vdly;
            sh_vwid   <= in_vwid;
            sh_flags  <= in_flags;
        end
    end
endmodule

// File: rtl/rtg_hcount.sv
// Pixel counter with horizontal sync and active-region decode.
// Assumes: hact+hblank is nonzero; run low holds the counter at 0.
module rtg_hcount #(
    parameter int unsigned H_W   = 13,
    parameter int unsigned HSW_W = 10,
    localparam int unsigned HC_W = H_W + 1,
    localparam int unsigned HE_W = HC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [H_W-1:0]   hact,
    input  logic [H_W-1:0]   hblank,
    input  logic [H_W-1:0]   hdly,
    input  logic [HSW_W-1:0] hwid,
    output logic [HC_W-1:0]  hcnt,
    output logic [HC_W-1:0]  hhalf,
    output logic             line_end,
    output logic             hs_raw,
    output logic             h_act
);
    logic [HC_W-1:0] htotal;
    logic [HE_W-1:0] hs_start;
    logic [HE_W-1:0] hs_stop;
    logic [HE_W-1:0] hcnt_e;

    // Line length, sync window and half-line point.
    always_comb begin
        htotal   = HC_W'(hact) + HC_W'(hblank);
        hhalf    = htotal >> 1;
        hs_start = HE_W'(hact) + HE_W'(hdly);
        hs_stop  = hs_start + HE_W'(hwid);
        hcnt_e   = HE_W'(hcnt);
        line_end = run && (hcnt == htotal - 1'b1);
        hs_raw   = (hcnt_e >= hs_start) && (hcnt_e < hs_stop);
        h_act    = hcnt < HC_W'(hact);
    end

    // Advance the pixel position, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            hcnt <= '0;
        else if (line_end)
            hcnt <= '0;
        else
            hcnt <= hcnt + 1'b1;
    end
endmodule

// File: rtl/rtg_vcount.sv
// Line counter, field tracking and vertical sync decode.
// Assumes: vact is nonzero; counts advance only on line_end.
module rtg_vcount #(
    parameter int unsigned VA_W  = 13,
    parameter int unsigned VB_W  = 8,
    parameter int unsigned VSW_W = 6,
    parameter int unsigned HC_W  = 14,
    localparam int unsigned VC_W = VA_W + 1,
    localparam int unsigned VE_W = VC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             line_end,
    input  logic [HC_W-1:0]  hcnt,
    input  logic [HC_W-1:0]  hhalf,
    input  logic [VA_W-1:0]  vact,
    input  logic [VB_W-1:0]  vblank,
    input  logic [VB_W-1:0]  vdly,
    input  logic [VSW_W-1:0] vwid,
    input  logic             ilace,
    input  logic             halfline,
    output logic [VC_W-1:0]  vcnt,
    output logic             fid,
    output logic             field_end,
    output logic             vs_raw,
    output logic             v_act
);
    logic            shifted;
    logic [VC_W-1:0] vlast;
    logic [VE_W-1:0] vs_first;
    logic [VE_W-1:0] vs_after;
    logic [VE_W-1:0] vcnt_e;
    logic            late_half;

    // Field length and vsync window, with the half-line variant.
    always_comb begin
        shifted   = ilace && halfline && fid;
        vlast     = VC_W'(vact) + VC_W'(vblank) - 1'b1 + VC_W'(shifted);
        field_end = line_end && (vcnt == vlast);
        vs_first  = VE_W'(vact) + VE_W'(vdly);
        vs_after  = vs_first + VE_W'(vwid);
        vcnt_e    = VE_W'(vcnt);
        late_half = hcnt >= hhalf;
        v_act     = vcnt < VC_W'(vact);
        if (shifted && (vwid != '0))
            vs_raw = ((vcnt_e == vs_first) && late_half) ||
                     ((vcnt_e > vs_first) && (vcnt_e < vs_after)) ||
                     ((vcnt_e == vs_after) && !late_half);
        else
            vs_raw = (vcnt_e >= vs_first) && (vcnt_e < vs_after);
    end

    // Advance the line position at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            vcnt <= '0;
        else if (field_end)
            vcnt <= '0;
        else if (line_end)
            vcnt <= vcnt + 1'b1;
    end

    // Flip the field at entry into vertical blanking when interlaced.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            fid <= 1'b0;
        else if (ilace && line_end && (vcnt == VC_W'(vact) - 1'b1))
            fid <= ~fid;
    end
endmodule

// File: rtl/rtg_top.sv
// Programmable raster timing generator: hsync, vsync, data enable and
// field ID from active/blanking sizes plus sync delay and width.
// Assumes: nonzero line length and vact; config stable around clock edges.
module rtg_top #(
    parameter int unsigned H_W   = rtg_pkg::H_W_DEF,
    parameter int unsigned HSW_W = rtg_pkg::HSW_W_DEF,
    parameter int unsigned VA_W  = rtg_pkg::VA_W_DEF,
    parameter int unsigned VB_W  = rtg_pkg::VB_W_DEF,
    parameter int unsigned VSW_W = rtg_pkg::VSW_W_DEF,
    localparam int unsigned HC_W = H_W + 1,
    localparam int unsigned VC_W = VA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [H_W-1:0]   cfg_hact,
    input  logic [H_W-1:0]   cfg_hblank,
    input  logic [H_W-1:0]   cfg_hdly,
    input  logic [HSW_W-1:0] cfg_hwid,
    input  logic [VA_W-1:0]  cfg_vact,
    input  logic [VB_W-1:0]  cfg_vblank,
    input  logic [VB_W-1:0]  cfg_vdly,
    input  logic [VSW_W-1:0] cfg_vwid,
    input  logic             cfg_hs_pol,
    input  logic             cfg_vs_pol,
    input  logic             cfg_de_pol,
    input  logic             cfg_ilace,
    input  logic             cfg_halfline,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             field_id,
    output logic [HC_W-1:0]  hcount,
    output logic [VC_W-1:0]  vcount
);
    logic             running;
    logic             run_cnt;
    logic             load;
    logic [H_W-1:0]   sh_hact, sh_hblank, sh_hdly;
    logic [HSW_W-1:0] sh_hwid;
    logic [VA_W-1:0]  sh_vact;
    logic [VB_W-1:0]  sh_vblank, sh_vdly;
    logic [VSW_W-1:0] sh_vwid;
    logic [4:0]       sh_flags;
    logic [HC_W-1:0]  hhalf;
    logic             line_end, field_end;
    logic             hs_raw, vs_raw, h_act, v_act, fid;
    logic [2:0]       raw_v, pol_v, out_v;

    // Track whether the raster is running (one clock behind en).
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else
            running <= en;
    end

    assign run_cnt = running && en;
    assign load    = !running || field_end;

    rtg_shadow #(
        .H_W(H_W), .HSW_W(HSW_W), .VA_W(VA_W), .VB_W(VB_W), .VSW_W(VSW_W)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_hact(cfg_hact), .in_hblank(cfg_hblank), .in_hdly(cfg_hdly),
        .in_hwid(cfg_hwid), .in_vact(cfg_vact), .in_vblank(cfg_vblank),
        .in_vdly(cfg_vdly), .in_vwid(cfg_vwid),
        .in_flags({cfg_halfline, cfg_ilace, cfg_de_pol, cfg_vs_pol, cfg_hs_pol}),
        .sh_hact(sh_hact), .sh_hblank(sh_hblank), .sh_hdly(sh_hdly),
        .sh_hwid(sh_hwid), .sh_vact(sh_vact), .sh_vblank(sh_vblank),
        .sh_vdly(sh_vdly), .sh_vwid(sh_vwid), .sh_flags(sh_flags)
    );

    rtg_hcount #(.H_W(H_W), .HSW_W(HSW_W)) u_hcount (
        .clk(clk), .rst_n(rst_n), .run(run_cnt),
        .hact(sh_hact), .hblank(sh_hblank), .hdly(sh_hdly), .hwid(sh_hwid),
        .hcnt(hcount), .hhalf(hhalf), .line_end(line_end),
        .hs_raw(hs_raw), .h_act(h_act)
    );

    rtg_vcount #(.VA_W(VA_W), .VB_W(VB_W), .VSW_W(VSW_W), .HC_W(HC_W)) u_vcount (
        .clk(clk), .rst_n(rst_n), .run(run_cnt), .line_end(line_end),
        .hcnt(hcount), .hhalf(hhalf),
        .vact(sh_vact), .vblank(sh_vblank), .vdly(sh_vdly), .vwid(sh_vwid),
        .ilace(sh_flags[3]), .halfline(sh_flags[4]),
        .vcnt(vcount), .fid(fid), .field_end(field_end),
        .vs_raw(vs_raw), .v_act(v_act)
    );

    // Gate strobes by the running state and apply per-signal polarity.
    assign raw_v = {running && h_act && v_act, running && vs_raw, running && hs_raw};
    assign pol_v = sh_flags[2:0];

    for (genvar i = 0; i < 3; i++) begin : g_pol
        assign out_v[i] = rtg_pkg::apply_pol(raw_v[i], pol_v[i]);
    end

    assign hsync    = out_v[0];
    assign vsync    = out_v[1];
    assign de       = out_v[2];
    assign field_id = fid && sh_flags[3];
endmodule

// File: rtl/rtg_checker.sv
// Temporal checks on the raster timing generator, bound to rtg_top.
module rtg_checker #(
    parameter int unsigned H_W  = 13,
    parameter int unsigned VA_W = 13,
    parameter int unsigned HC_W = 14,
    parameter int unsigned VC_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            running,
    input logic            line_end,
    input logic            field_end,
    input logic [HC_W-1:0] hcount,
    input logic [VC_W-1:0] vcount,
    input logic            field_id,
    input logic            de,
    input logic [H_W-1:0]  sh_hact,
    input logic [VA_W-1:0] sh_vact,
    input logic [4:0]      sh_flags
);
    // R1: pixel position steps by one or wraps to zero
    p_hcount_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && hcount != '0) |=> (hcount == $past(hcount) + 1'b1) || (hcount == '0));

    // R1: line position holds except at a line end
    p_vcount_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && !line_end) |=> $stable(vcount));

    // R2: no data enable on blanking lines
    p_de_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && vcount >= VC_W'(sh_vact)) |-> (de == !sh_flags[2]));

    // R6: field flips entering vertical blanking when interlaced
    p_field_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && sh_flags[3] && line_end && vcount == VC_W'(sh_vact) - 1'b1)
        |=> (field_id != $past(field_id)));

    // R8: shadow configuration holds inside a field
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && !field_end) |=> ($stable(sh_hact) && $stable(sh_vact) && $stable(sh_flags)));

    // R9: dropping enable returns to the origin
    p_idle_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hcount == '0 && vcount == '0 && field_id == 1'b0));
endmodule

bind rtg_top rtg_checker #(.H_W(H_W), .VA_W(VA_W), .HC_W(HC_W), .VC_W(VC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .running(running),
    .line_end(line_end), .field_end(field_end),
    .hcount(hcount), .vcount(vcount), .field_id(field_id), .de(de),
    .sh_hact(sh_hact), .sh_vact(sh_vact), .sh_flags(sh_flags)
);

// File: tb/rtg_top_tb.sv
module rtg_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [12:0] c_hact = 13'd8, c_hblank = 13'd6, c_hdly = 13'd2, c_vact = 13'd4;
    logic [9:0]  c_hwid = 10'd3;
    logic [7:0]  c_vblank = 8'd3, c_vdly = 8'd1;
    logic [5:0]  c_vwid = 6'd1;
    logic c_hsp = 1'b1, c_vsp = 1'b1, c_dep = 1'b1, c_il = 1'b0, c_half = 1'b0;
    logic hsync, vsync, de, field_id;
    logic [13:0] hcount, vcount;

    int checks = 0;
    int failures = 0;
    int m_hact, m_hblank, m_hdly, m_hwid, m_vact, m_vblank, m_vdly, m_vwid;
    int m_hsp, m_vsp, m_dep, m_il, m_half;

    always #10 clk = ~clk;

    rtg_top u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_hact(c_hact), .cfg_hblank(c_hblank), .cfg_hdly(c_hdly), .cfg_hwid(c_hwid),
        .cfg_vact(c_vact), .cfg_vblank(c_vblank), .cfg_vdly(c_vdly), .cfg_vwid(c_vwid),
        .cfg_hs_pol(c_hsp), .cfg_vs_pol(c_vsp), .cfg_de_pol(c_dep),
        .cfg_ilace(c_il), .cfg_halfline(c_half),
        .hsync(hsync), .vsync(vsync), .de(de), .field_id(field_id),
        .hcount(hcount), .vcount(vcount)
    );

    typedef struct packed {
        logic [12:0] hact; logic [12:0] hblank; logic [12:0] hdly; logic [9:0] hwid;
        logic [12:0] vact; logic [7:0] vblank; logic [7:0] vdly; logic [5:0] vwid;
        logic hsp; logic vsp; logic dep; logic il; logic half;
        logic [3:0] nf; logic [15:0] exp_de; logic [7:0] lines_even; logic [7:0] lines_odd;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{13'd8,  13'd6, 13'd2, 10'd3, 13'd4, 8'd3, 8'd1, 6'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 16'd32, 8'd7, 8'd7},
        '{13'd10, 13'd4, 13'd0, 10'd2, 13'd3, 8'd4, 8'd0, 6'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 16'd30, 8'd7, 8'd7},
        '{13'd8,  13'd6, 13'd1, 10'd2, 13'd3, 8'd2, 8'd0, 6'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4, 16'd24, 8'd5, 8'd5},
        '{13'd8,  13'd8, 13'd2, 10'd3, 13'd3, 8'd2, 8'd0, 6'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd4, 16'd24, 8'd6, 8'd5},
        '{13'd6,  13'd5, 13'd1, 10'd1, 13'd2, 8'd2, 8'd1, 6'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4, 16'd12, 8'd5, 8'd4}
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_vec(input vec_t v);
        c_hact = v.hact; c_hblank = v.hblank; c_hdly = v.hdly; c_hwid = v.hwid;
        c_vact = v.vact; c_vblank = v.vblank; c_vdly = v.vdly; c_vwid = v.vwid;
        c_hsp = v.hsp; c_vsp = v.vsp; c_dep = v.dep; c_il = v.il; c_half = v.half;
    endtask

    task automatic load_model();
        m_hact = int'(c_hact); m_hblank = int'(c_hblank); m_hdly = int'(c_hdly);
        m_hwid = int'(c_hwid); m_vact = int'(c_vact); m_vblank = int'(c_vblank);
        m_vdly = int'(c_vdly); m_vwid = int'(c_vwid);
        m_hsp = int'(c_hsp); m_vsp = int'(c_vsp); m_dep = int'(c_dep);
        m_il = int'(c_il); m_half = int'(c_half);
    endtask

    // Idle strobes must sit at their inactive level (R5).
    task automatic check_idle(input string req);
        chk(hsync == !c_hsp, req, "idle hsync", int'(hsync), int'(!c_hsp));
        chk(vsync == !c_vsp, req, "idle vsync", int'(vsync), int'(!c_vsp));
        chk(de == !c_dep, req, "idle de", int'(de), int'(!c_dep));
    endtask

    // Walk nf fields pixel by pixel against a model of R1..R9.
    task automatic walk(input int nf, input int de0, input int de1, input int ln_even,
                        input int ln_odd, input int chg_at, input int chg_hact);
        int ph = 0, pv = 0, pf = 0, f = 0, dec = 0, maxv = 0, cyc = 0;
        load_model();
        while (f < nf) begin
            int ht, extra, vs0, vs1, half, exp_h, exp_v, exp_d;
            bit r_de, r_hs, r_vs, fe;
            string vreq, freq;
            ht = m_hact + m_hblank;
            extra = (m_il != 0 && m_half != 0 && pf != 0) ? 1 : 0;
            r_de = (ph < m_hact) && (pv < m_vact);
            r_hs = (ph >= m_hact + m_hdly) && (ph < m_hact + m_hdly + m_hwid);
            vs0 = m_vact + m_vdly;
            vs1 = vs0 + m_vwid;
            half = ht / 2;
            if (extra != 0 && m_vwid != 0) begin
                r_vs = (pv == vs0 && ph >= half) || (pv > vs0 && pv < vs1) || (pv == vs1 && ph < half);
                vreq = "R7";
            end else begin
                r_vs = (pv >= vs0) && (pv < vs1);
                vreq = "R4";
            end
            exp_h = (m_hsp != 0) ? int'(r_hs) : int'(!r_hs);
            exp_v = (m_vsp != 0) ? int'(r_vs) : int'(!r_vs);
            exp_d = (m_dep != 0) ? int'(r_de) : int'(!r_de);
            freq = (cyc == 0) ? "R9" : "R1";
            chk(int'(hcount) == ph, freq, "hcount", int'(hcount), ph);
            chk(int'(vcount) == pv, freq, "vcount", int'(vcount), pv);
            chk(int'(de) == exp_d, "R2", "de", int'(de), exp_d);
            chk(int'(hsync) == exp_h, "R3", "hsync", int'(hsync), exp_h);
            chk(int'(vsync) == exp_v, vreq, "vsync", int'(vsync), exp_v);
            chk(int'(field_id) == ((m_il != 0) ? pf : 0), "R6", "field_id", int'(field_id), (m_il != 0) ? pf : 0);
            if (int'(de) == m_dep) dec++;
            if (int'(vcount) > maxv) maxv = int'(vcount);
            cyc++;
            if (cyc == chg_at) c_hact = 13'(chg_hact);
            fe = 1'b0;
            if (ph == ht - 1) begin
                ph = 0;
                if (pv == m_vact + m_vblank - 1 + extra) begin
                    pv = 0;
                    fe = 1'b1;
                end else begin
                    pv++;
                    if (pv == m_vact && m_il != 0) pf = 1 - pf;
                end
            end else begin
                ph++;
            end
            if (fe) begin
                chk(dec == ((f == 0) ? de0 : de1), "R8", "active pixels in field", dec, (f == 0) ? de0 : de1);
                chk(maxv + 1 == ((f % 2 == 0) ? ln_even : ln_odd), "R7", "lines in field",
                    maxv + 1, (f % 2 == 0) ? ln_even : ln_odd);
                f++;
                dec = 0;
                maxv = 0;
                load_model();
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(hcount == 14'd0, "R10", "reset hcount", int'(hcount), 0);
        chk(vcount == 14'd0, "R10", "reset vcount", int'(vcount), 0);
        chk(field_id == 1'b0, "R10", "reset field_id", int'(field_id), 0);
        rst_n = 1'b1;

        // Table of configurations walked by one loop
        for (int i = 0; i < NVEC; i++) begin
            en = 1'b0;
            apply_vec(VECS[i]);
            repeat (3) @(negedge clk);
            check_idle("R5");
            en = 1'b1;
            @(negedge clk);
            walk(int'(VECS[i].nf), int'(VECS[i].exp_de), int'(VECS[i].exp_de),
                 int'(VECS[i].lines_even), int'(VECS[i].lines_odd), -1, 0);
        end

        // R8: mid-field width change takes effect at the next field only
        en = 1'b0;
        apply_vec(VECS[0]);
        repeat (3) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        walk(3, 32, 24, 7, 7, 20, 6);

        // R9: disable at the start of field 1, then restart from the origin
        en = 1'b0;
        apply_vec(VECS[3]);
        repeat (3) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        walk(1, 24, 24, 6, 6, -1, 0);
        chk(field_id == 1'b1, "R6", "field after first blanking", int'(field_id), 1);
        en = 1'b0;
        @(negedge clk);
        chk(hcount == 14'd0, "R9", "disable hcount", int'(hcount), 0);
        chk(vcount == 14'd0, "R9", "disable vcount", int'(vcount), 0);
        chk(field_id == 1'b0, "R9", "disable field_id", int'(field_id), 0);
        check_idle("R9");
        en = 1'b1;
        @(negedge clk);
        walk(2, 24, 24, 6, 5, -1, 0);

        // R10: synchronous reset in the middle of a line
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(hcount == 14'd0, "R10", "mid-run reset hcount", int'(hcount), 0);
        chk(vcount == 14'd0, "R10", "mid-run reset vcount", int'(vcount), 0);
        chk(field_id == 1'b0, "R10", "mid-run reset field_id", int'(field_id), 0);
        en = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule